// File: doc/BRIEF.md
# Hall-Filtered Capture Timer Channel

This block is a single channel of a motor-control timer. It keeps a free-running timer counter that counts clock cycles up to a programmable limit. It watches one capture pin, usually wired to a Hall-effect sensor, and on a chosen transition of that pin it records the counter into a capture register. The same capture can also raise a sticky interrupt flag and, if configured, restart the counter exactly as a limit match would. A limit/restart event pulse is sent out for a neighbouring PWM output stage.

Hall sensors bounce when a motor commutates. For this reason a capture edge can instead start a dead-time down-counter. Every capture action then waits until that counter has run out, and any further pin transitions in that window are ignored. A separate counter mode makes the timer advance on chosen pin transitions instead of on every clock. In that mode the capture path works as usual.

Top module: `hallcap_channel`

## Requirements
- R1: The capture pin passes through two synchronizer flops, and a transition is then detected by comparison with the previous synchronized level. With the filter off, a rising transition (when `cfg_cap_rise` is 1) or a falling one (when `cfg_cap_fall` is 1) takes effect on the third rising clock edge at which the new pin level is present. A transition of a kind not enabled causes no capture and no flag.
- R2: A capture event loads `cap_value` with the `tc_value` that was held just before the clock edge that performs the capture.
- R3: When `cfg_irq_en` is 1, a capture event sets `irq_flag`. The flag stays at 1 until a cycle with `irq_clr` high clears it. If a set and a clear fall on the same edge, the flag stays at 1.
- R4: When `cfg_reset_on_cap` is 1, a capture event clears `tc_value` to 0 and raises `limit_evt` for the one cycle that follows, the same as a limit match. This takes priority over counting.
- R5: When `cfg_filter_en` is 1, a selected transition loads the dead-time counter with `dt_reload` = D. The capture actions then happen D+1 clock edges later than they would with the filter off.
- R6: While the dead-time counter is running, selected transitions of the pin are ignored. They neither restart the window nor cause a second capture.
- R7: With `cfg_count_mode` at 0, `tc_value` rises by one on every clock edge. At the edge where it equals `limit` it returns to 0 instead, and `limit_evt` is 1 in the following cycle. `limit_evt` is 1 only in cycles where `tc_value` is 0.
- R8: With `cfg_count_mode` at 1, `tc_value` advances (with the same wrap at `limit` and the same `limit_evt`) only for pin transitions selected by `cfg_cnt_rise`/`cfg_cnt_fall`. It uses the same synchronizer latency as R1 and otherwise holds its value.
- R9: A clock edge with `rst_n` low clears `tc_value`, `cap_value`, `irq_flag`, `limit_evt` and the dead-time state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_pin | input | 1 | Asynchronous Hall/capture input |
| cfg_cap_rise | input | 1 | Rising transitions trigger capture |
| cfg_cap_fall | input | 1 | Falling transitions trigger capture |
| cfg_filter_en | input | 1 | Delay capture actions through the dead-time counter |
| cfg_irq_en | input | 1 | Capture sets the interrupt flag |
| cfg_reset_on_cap | input | 1 | Capture restarts the timer like a limit match |
| cfg_count_mode | input | 1 | Timer counts pin transitions instead of clocks |
| cfg_cnt_rise | input | 1 | Rising transitions advance the timer in counter mode |
| cfg_cnt_fall | input | 1 | Falling transitions advance the timer in counter mode |
| dt_reload | input | DT_W | Dead-time reload value |
| limit | input | CNT_W | Timer wrap value |
| irq_clr | input | 1 | Write-one-to-clear strobe for the flag |
| tc_value | output | CNT_W | Timer counter |
| cap_value | output | CNT_W | Capture register |
| irq_flag | output | 1 | Sticky capture interrupt flag |
| limit_evt | output | 1 | One-cycle limit/restart event |

## Verification
The bench sweeps the capture edge over both polarities, with the filter off and with several dead-time lengths, at different arrival times. It checks that nothing happens one cycle before the computed edge and that the exact pre-edge count is captured on it. A synchronizer with the wrong depth, or a filter off by one, therefore shows up as a wrong count or a capture that came too early. A second transition is placed inside a running dead-time window. A filter that restarts there captures late and with a different value. The bench also checks a clear that meets a new set on the same edge, where a design that lets the clear win would drop the flag. Wrap at the limit, including a limit of zero, and counter mode with each edge polarity are checked, so a timer that counts on the wrong polarity or in the wrong mode drifts from the arithmetic count.

// File: rtl/hallcap_pkg.sv
// Package hallcap_pkg
// Shared types and helpers for the Hall-filtered capture channel.
// Assumes: edge selections are given as separate rise/fall enables.
package hallcap_pkg;

    // Which transitions of the synchronized pin are of interest
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_sel_t;

    // True when a detected transition matches the selection
    function automatic logic edge_hit(edge_sel_t sel, logic is_rise, logic is_fall);
        return (sel.rise & is_rise) | (sel.fall & is_fall);
    endfunction

endpackage

// File: rtl/hallcap_sync_edge.sv
// Module hallcap_sync_edge
// Brings an asynchronous pin into the clock domain through a chain of
// STAGES flops and flags rising and falling transitions of the result
// by comparison with the level one cycle earlier.
// Assumes: STAGES >= 2; reset level of the chain is low.
module hallcap_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic is_rise,
    output logic is_fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // First synchronizer stage samples the raw pin
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= pin;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Further synchronizer stages shift the level along
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    // Remember the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[LAST];
    end

    // Combinational transition flags
    always_comb begin
        level   = chain_q[LAST];
        is_rise = chain_q[LAST] & ~prev_q;
        is_fall = ~chain_q[LAST] & prev_q;
    end

endmodule

// File: rtl/hallcap_deadtime.sv
// Module hallcap_deadtime
// Optional noise filter. When enabled, a trigger loads a down-counter
// with the reload value; the fire output pulses in the cycle the count
// is at zero. Triggers while the counter runs are dropped. When
// disabled, the trigger passes straight through to fire.
// Assumes: reload is stable while a window is running.
module hallcap_deadtime #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            trig,
    input  logic [DT_W-1:0] reload,
    output logic            fire,
    output logic            busy
);
    logic [DT_W-1:0] cnt_q;
    logic            busy_q;

    // Run the dead-time window: load on trigger, count down, then end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (!enable) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end else if (trig) begin
            cnt_q  <= reload;
            busy_q <= 1'b1;
        end
    end

    // Select between delayed and direct capture event
    always_comb begin
        busy = busy_q;
        if (enable) fire = busy_q && (cnt_q == '0);
        else        fire = trig;
    end

endmodule

// File: rtl/hallcap_timer.sv
// Module hallcap_timer
// Timer counter with wrap at a limit. Advances every clock, or only on
// qualified pin transitions in counter mode. A restart request clears
// it with priority. Any wrap or restart raises a one-cycle event.
// Assumes: limit may change at any time; a count above it runs on to
// the natural roll-over.
module hallcap_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_mode,
    input  logic             tick_edge,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] tc,
    output logic             wrap_evt
);
    logic [CNT_W-1:0] tc_q;
    logic             evt_q;
    logic             advance;

    // Decide whether this cycle moves the counter
    always_comb begin
        advance = count_mode ? tick_edge : 1'b1;
    end

    // Count, wrap at the limit, or restart on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q  <= '0;
            evt_q <= 1'b0;
        end else begin
            evt_q <= 1'b0;
            if (restart) begin
                tc_q  <= '0;
                evt_q <= 1'b1;
            end else if (advance) begin
                if (tc_q == limit) begin
                    tc_q  <= '0;
                    evt_q <= 1'b1;
                end else begin
                    tc_q <= tc_q + 1'b1;
                end
            end
        end
    end

    // Drive outputs from the registers
    always_comb begin
        tc       = tc_q;
        wrap_evt = evt_q;
    end

endmodule

// File: rtl/hallcap_capture.sv
// Module hallcap_capture
// Capture register and sticky interrupt flag. A capture event stores
// the current count; with the interrupt enabled it sets the flag, which
// only a clear strobe removes. Set beats clear on the same edge.
// Assumes: capture events are single-cycle pulses.
module hallcap_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_evt,
    input  logic [CNT_W-1:0] tc,
    input  logic             irq_en,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] cap_value,
    output logic             irq_flag
);
    logic [CNT_W-1:0] cap_q;
    logic             flag_q;

    // Store the count on a capture event
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (cap_evt) cap_q <= tc;
    end

    // Sticky flag with set priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag_q <= 1'b0;
        else if (cap_evt && irq_en) flag_q <= 1'b1;
        else if (irq_clr)           flag_q <= 1'b0;
    end

    // Drive outputs from the registers
    always_comb begin
        cap_value = cap_q;
        irq_flag  = flag_q;
    end

endmodule

// File: rtl/hallcap_channel.sv
// Module hallcap_channel
// One timer channel with Hall-sensor capture. Synchronizes the capture
// pin, routes selected transitions through an optional dead-time filter
// into the capture register, flag and restart logic, and feeds counter
// mode ticks to the timer.
// Assumes: configuration is quasi-static; the PWM stage consumes limit_evt.
module hallcap_channel
    import hallcap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DT_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin,
    input  logic             cfg_cap_rise,
    input  logic             cfg_cap_fall,
    input  logic             cfg_filter_en,
    input  logic             cfg_irq_en,
    input  logic             cfg_reset_on_cap,
    input  logic             cfg_count_mode,
    input  logic             cfg_cnt_rise,
    input  logic             cfg_cnt_fall,
    input  logic [DT_W-1:0]  dt_reload,
    input  logic [CNT_W-1:0] limit,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] tc_value,
    output logic [CNT_W-1:0] cap_value,
    output logic             irq_flag,
    output logic             limit_evt
);
    logic      pin_level;
    logic      pin_rise;
    logic      pin_fall;
    edge_sel_t cap_sel;
    edge_sel_t cnt_sel;
    logic      cap_trig;
    logic      cap_fire;
    logic      dt_busy;
    logic      cnt_hit;
    logic      cap_restart;

    // Pack edge selections and qualify detected transitions
    always_comb begin
        cap_sel     = '{rise: cfg_cap_rise, fall: cfg_cap_fall};
        cnt_sel     = '{rise: cfg_cnt_rise, fall: cfg_cnt_fall};
        cap_trig    = edge_hit(cap_sel, pin_rise, pin_fall);
        cnt_hit     = edge_hit(cnt_sel, pin_rise, pin_fall);
        cap_restart = cap_fire & cfg_reset_on_cap;
    end

    hallcap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (cap_pin),
        .level   (pin_level),
        .is_rise (pin_rise),
        .is_fall (pin_fall)
    );

    hallcap_deadtime #(.DT_W(DT_W)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (cfg_filter_en),
        .trig   (cap_trig),
        .reload (dt_reload),
        .fire   (cap_fire),
        .busy   (dt_busy)
    );

    hallcap_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_mode (cfg_count_mode),
        .tick_edge  (cnt_hit),
        .restart    (cap_restart),
        .limit      (limit),
        .tc         (tc_value),
        .wrap_evt   (limit_evt)
    );

    hallcap_capture #(.CNT_W(CNT_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_evt   (cap_fire),
        .tc        (tc_value),
        .irq_en    (cfg_irq_en),
        .irq_clr   (irq_clr),
        .cap_value (cap_value),
        .irq_flag  (irq_flag)
    );

endmodule

// File: rtl/hallcap_channel_chk.sv
// Module hallcap_channel_chk
// Temporal checks for hallcap_channel, attached by bind below. Watches
// the ports plus the filter's fire/busy and the counter-mode tick.
// Assumes: synchronous active-low reset on the checked block.
module hallcap_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_filter_en,
    input logic             cfg_irq_en,
    input logic             cfg_reset_on_cap,
    input logic             cfg_count_mode,
    input logic             irq_clr,
    input logic [CNT_W-1:0] limit,
    input logic [CNT_W-1:0] tc_value,
    input logic [CNT_W-1:0] cap_value,
    input logic             irq_flag,
    input logic             limit_evt,
    input logic             cap_fire,
    input logic             dt_busy,
    input logic             cnt_hit
);
    localparam logic [CNT_W-1:0] ONE = 1;

    assert_capture_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> (cap_value == $past(tc_value)));

    assert_irq_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_fire && cfg_irq_en) |=> irq_flag);

    assert_irq_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    assert_irq_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !(cap_fire && cfg_irq_en)) |=> !irq_flag);

    assert_cap_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_fire && cfg_reset_on_cap) |=> (tc_value == '0 && limit_evt));

    assert_window_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_filter_en && dt_busy && !cap_fire) |=> (dt_busy || !cfg_filter_en));

    assert_evt_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        limit_evt |-> (tc_value == '0));

    assert_clock_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_count_mode && !(cap_fire && cfg_reset_on_cap) && tc_value < limit)
        |=> (tc_value == ($past(tc_value) + ONE)));

    assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_count_mode && !cnt_hit && !(cap_fire && cfg_reset_on_cap))
        |=> $stable(tc_value));

endmodule

bind hallcap_channel hallcap_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_filter_en    (cfg_filter_en),
    .cfg_irq_en       (cfg_irq_en),
    .cfg_reset_on_cap (cfg_reset_on_cap),
    .cfg_count_mode   (cfg_count_mode),
    .irq_clr          (irq_clr),
    .limit            (limit),
    .tc_value         (tc_value),
    .cap_value        (cap_value),
    .irq_flag         (irq_flag),
    .limit_evt        (limit_evt),
    .cap_fire         (cap_fire),
    .dt_busy          (dt_busy),
    .cnt_hit          (cnt_hit)
);

// File: tb/hallcap_channel_test.sv
// Bench for hallcap_channel: directed sweeps with arithmetic expectations.
// Inputs change and outputs are sampled on falling clock edges.
module hallcap_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_pin = 1'b0;
    logic        cfg_cap_rise = 1'b0;
    logic        cfg_cap_fall = 1'b0;
    logic        cfg_filter_en = 1'b0;
    logic        cfg_irq_en = 1'b0;
    logic        cfg_reset_on_cap = 1'b0;
    logic        cfg_count_mode = 1'b0;
    logic        cfg_cnt_rise = 1'b0;
    logic        cfg_cnt_fall = 1'b0;
    logic [7:0]  dt_reload = '0;
    logic [15:0] limit = '0;
    logic        irq_clr = 1'b0;
    logic [15:0] tc_value;
    logic [15:0] cap_value;
    logic        irq_flag;
    logic        limit_evt;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    hallcap_channel uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .cap_pin          (cap_pin),
        .cfg_cap_rise     (cfg_cap_rise),
        .cfg_cap_fall     (cfg_cap_fall),
        .cfg_filter_en    (cfg_filter_en),
        .cfg_irq_en       (cfg_irq_en),
        .cfg_reset_on_cap (cfg_reset_on_cap),
        .cfg_count_mode   (cfg_count_mode),
        .cfg_cnt_rise     (cfg_cnt_rise),
        .cfg_cnt_fall     (cfg_cnt_fall),
        .dt_reload        (dt_reload),
        .limit            (limit),
        .irq_clr          (irq_clr),
        .tc_value         (tc_value),
        .cap_value        (cap_value),
        .irq_flag         (irq_flag),
        .limit_evt        (limit_evt)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Hold reset for three edges; returns at a falling edge with count 0
    task automatic do_reset();
        rst_n   = 1'b0;
        irq_clr = 1'b0;
        wait_edges(3);
        rst_n = 1'b1;
    endtask

    task automatic clear_cfg();
        cfg_cap_rise = 0; cfg_cap_fall = 0; cfg_filter_en = 0; cfg_irq_en = 0;
        cfg_reset_on_cap = 0; cfg_count_mode = 0; cfg_cnt_rise = 0; cfg_cnt_fall = 0;
        dt_reload = '0; limit = 16'd60000; cap_pin = 1'b0;
    endtask

    // One capture scenario; timer counts clocks so tc equals edges since reset
    task automatic cap_case(input bit use_fall, input bit filt, input int d,
                            input int m, input bit irqe);
        int act_edge;
        string tg;
        clear_cfg();
        cfg_cap_rise  = !use_fall;
        cfg_cap_fall  = use_fall;
        cfg_filter_en = filt;
        dt_reload     = d[7:0];
        cfg_irq_en    = irqe;
        cap_pin       = use_fall;
        do_reset();
        wait_edges(m);
        cap_pin  = !use_fall;
        act_edge = m + 3 + (filt ? d + 1 : 0);
        tg = filt ? "R5" : "R1";
        wait_edges(act_edge - 1 - m);
        check({tg, " not yet captured"}, int'(cap_value), 0);
        check({tg, " R3 flag not yet set"}, int'(irq_flag), 0);
        wait_edges(1);
        check({tg, " R2 captured count"}, int'(cap_value), act_edge - 1);
        check("R3 flag follows enable", int'(irq_flag), int'(irqe));
    endtask

    initial begin
        // Normal clock counting with wrap at 5 (R7), then reset clears (R9)
        clear_cfg();
        limit = 16'd5;
        do_reset();
        check("R9 tc after reset", int'(tc_value), 0);
        check("R9 evt after reset", int'(limit_evt), 0);
        for (int n = 1; n <= 20; n++) begin
            wait_edges(1);
            check("R7 count", int'(tc_value), n % 6);
            check("R7 limit event", int'(limit_evt), int'(n % 6 == 0 && n > 0));
        end

        // Limit of zero: counter pinned at 0 with event each cycle (R7)
        limit = 16'd0;
        do_reset();
        wait_edges(3);
        check("R7 limit zero count", int'(tc_value), 0);
        check("R7 limit zero event", int'(limit_evt), 1);

        // Capture sweep over polarity, filter, dead time, arrival (R1 R2 R3 R5)
        for (int pol = 0; pol < 2; pol++)
            for (int f = 0; f < 2; f++)
                for (int di = 0; di < 3; di++)
                    for (int mi = 0; mi < 2; mi++)
                        cap_case(pol[0], f[0], (di == 0) ? 0 : (di == 1) ? 1 : 4,
                                 (mi == 0) ? 4 : 9, mi[0]);

        // Reset state after activity (R9)
        rst_n = 1'b0;
        wait_edges(1);
        check("R9 tc cleared", int'(tc_value), 0);
        check("R9 cap cleared", int'(cap_value), 0);
        check("R9 flag cleared", int'(irq_flag), 0);
        check("R9 event cleared", int'(limit_evt), 0);

        // Unselected transitions do nothing (R1)
        clear_cfg();
        cfg_irq_en = 1;
        do_reset();
        for (int t = 0; t < 4; t++) begin
            wait_edges(4);
            cap_pin = ~cap_pin;
        end
        wait_edges(5);
        check("R1 unselected edge no capture", int'(cap_value), 0);
        check("R1 unselected edge no flag", int'(irq_flag), 0);

        // Restart on capture (R4): rise after edge 10, acts at edge 13
        clear_cfg();
        cfg_cap_rise = 1; cfg_reset_on_cap = 1;
        do_reset();
        wait_edges(10);
        cap_pin = 1'b1;
        wait_edges(3);
        check("R4 tc restarted", int'(tc_value), 0);
        check("R4 event pulse", int'(limit_evt), 1);
        check("R4 R2 captured", int'(cap_value), 12);
        wait_edges(1);
        check("R4 counting resumes", int'(tc_value), 1);
        check("R4 event one cycle", int'(limit_evt), 0);

        // Edges inside running window ignored (R6), later edge works (R5)
        clear_cfg();
        cfg_cap_rise = 1; cfg_cap_fall = 1; cfg_filter_en = 1; dt_reload = 8'd6;
        do_reset();
        wait_edges(5);
        cap_pin = 1'b1;
        wait_edges(2);
        cap_pin = 1'b0;
        wait_edges(8);
        check("R6 first capture not restarted", int'(cap_value), 14);
        wait_edges(10);
        check("R6 no second capture", int'(cap_value), 14);
        wait_edges(5);
        cap_pin = 1'b1;
        wait_edges(10);
        check("R5 new window after expiry", int'(cap_value), 39);

        // Flag clear and set-beats-clear (R3)
        clear_cfg();
        cfg_cap_rise = 1; cfg_irq_en = 1;
        do_reset();
        wait_edges(5);
        cap_pin = 1'b1;
        wait_edges(3);
        check("R3 flag set", int'(irq_flag), 1);
        wait_edges(2);
        irq_clr = 1'b1;
        wait_edges(1);
        irq_clr = 1'b0;
        check("R3 flag cleared", int'(irq_flag), 0);
        cap_pin = 1'b0;
        wait_edges(3);
        cap_pin = 1'b1;
        wait_edges(2);
        irq_clr = 1'b1;
        wait_edges(1);
        check("R3 set wins over clear", int'(irq_flag), 1);
        check("R3 R2 second capture", int'(cap_value), 16);
        irq_clr = 1'b0;
        wait_edges(1);
        check("R3 flag stays", int'(irq_flag), 1);

        // Counter mode, rising then falling selection, wrap at 3 (R8)
        for (int sel = 0; sel < 2; sel++) begin
            int cnt;
            clear_cfg();
            limit = 16'd3;
            cfg_count_mode = 1;
            cfg_cnt_rise = (sel == 0);
            cfg_cnt_fall = (sel == 1);
            do_reset();
            wait_edges(4);
            check("R8 no clock counting", int'(tc_value), 0);
            cnt = 0;
            for (int j = 1; j <= 12; j++) begin
                bit qual;
                cap_pin = ~cap_pin;
                qual = (cap_pin == 1'b1) ? (sel == 0) : (sel == 1);
                wait_edges(2);
                check("R8 latency hold", int'(tc_value), cnt % 4);
                wait_edges(1);
                if (qual) cnt++;
                check("R8 edge count", int'(tc_value), cnt % 4);
                check("R8 wrap event", int'(limit_evt), int'(qual && (cnt % 4 == 0)));
                wait_edges(1);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule